// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Exported Carry Terms

This block is a purely combinational integer ALU whose width is set by a parameter. It is built as a ripple chain of identical one-bit cells, with a separate cell in the top position. That top cell also produces the signed-comparison bit and the signed overflow indication. Either operand can be bitwise complemented before it enters the cells. The carry into bit 0 equals the complement control of the second operand, so subtraction is addition of the complemented second operand with a carry-in of one.

Besides the result and its flags, the block exports, for every bit position, the carry-propagate and carry-generate terms of the (possibly complemented) operands. A lookahead carry unit outside the block can use them. The internal carry still ripples.

Top module: `alu_sliced`

## Requirements
- R1: With op_sel = 2'b00 the result is the bitwise AND of the effective operands. The effective operand is `~a` when inv_a is 1 and `a` otherwise, and likewise `~b` for inv_b.
- R2: With op_sel = 2'b01 the result is the bitwise OR of the effective operands.
- R3: With op_sel = 2'b10 the result is (effective a + effective b + inv_b) modulo 2^WIDTH, so the carry into bit 0 equals inv_b.
- R4: With op_sel = 2'b10, inv_a = 0 and inv_b = 1, the result is (a - b) modulo 2^WIDTH.
- R5: With op_sel = 2'b11, bit 0 of the result is 1 exactly when the true signed value of (effective a + effective b + inv_b) is negative, and all other result bits are 0. With inv_a = 0 and inv_b = 1 this is a signed a < b test, and it stays correct when the subtraction overflows.
- R6: zero is 1 exactly when every result bit is 0.
- R7: With op_sel = 2'b10 or 2'b11, overflow is 1 exactly when the signed sum (effective a + effective b + inv_b) lies outside the signed WIDTH-bit range.
- R8: With op_sel = 2'b00 or 2'b01, overflow is 0.
- R9: For every bit i, prop[i] is (effective a[i] OR effective b[i]) and gen[i] is (effective a[i] AND effective b[i]).
- R10: WIDTH can be any value from 2 to 32, with a default of 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| inv_a | input | 1 | Complement the first operand before use |
| inv_b | input | 1 | Complement the second operand; also the carry into bit 0 |
| op_sel | input | 2 | 00 AND, 01 OR, 10 add, 11 signed less-than |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of the arithmetic operation |
| prop | output | WIDTH | Per-bit carry propagate of effective operands |
| gen | output | WIDTH | Per-bit carry generate of effective operands |

## Verification
The block holds no state, so any fault shows at the ports within the same evaluation as the input change. A broken carry link corrupts the sum at and above the faulty bit, and shows first on operand pairs whose carries cross that bit. A wrong top cell shows as a wrong comparison or overflow only for the pairs whose subtraction overflows. Sweeping every operand pair, every operation and every complement setting at widths 4 and 2 reaches each of these cases.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SLT = 2'b11
    } alu_op_e;

endpackage

// File: rtl/alu_slice.sv
// One ordinary bit cell: operand complement, carry terms, full add, output select.
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    inv_a,
    input  logic    inv_b,
    input  logic    carry_in,
    input  logic    less_in,
    input  alu_op_e op,
    output logic    res,
    output logic    carry_out,
    output logic    prop,
    output logic    gen
);
    logic a_m;
    logic b_m;
    logic sum;

    assign a_m       = a_i ^ inv_a;
    assign b_m       = b_i ^ inv_b;
    assign prop      = a_m | b_m;
    assign gen       = a_m & b_m;
    assign sum       = a_m ^ b_m ^ carry_in;
    assign carry_out = gen | (prop & carry_in);

    always_comb begin
        unique case (op)
            OP_AND:  res = gen;
            OP_OR:   res = prop;
            OP_ADD:  res = sum;
            OP_SLT:  res = less_in;
            default: res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_msb_slice.sv
// Top bit cell: like an ordinary cell, plus signed overflow and the less-than bit.
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    inv_a,
    input  logic    inv_b,
    input  logic    carry_in,
    input  alu_op_e op,
    output logic    res,
    output logic    prop,
    output logic    gen,
    output logic    ovf,
    output logic    set_lt
);
    logic a_m;
    logic b_m;
    logic sum;
    logic carry_out;

    assign a_m       = a_i ^ inv_a;
    assign b_m       = b_i ^ inv_b;
    assign prop      = a_m | b_m;
    assign gen       = a_m & b_m;
    assign sum       = a_m ^ b_m ^ carry_in;
    assign carry_out = gen | (prop & carry_in);
    // Signed overflow: carry into the sign bit differs from the carry out of it.
    assign ovf       = carry_in ^ carry_out;
    // The true sign of the sum is the sign bit, corrected by overflow.
    assign set_lt    = sum ^ ovf;

    always_comb begin
        unique case (op)
            OP_AND:  res = gen;
            OP_OR:   res = prop;
            OP_ADD:  res = sum;
            OP_SLT:  res = 1'b0;
            default: res = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_zero_flag.sv
module alu_zero_flag #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);
    assign is_zero = ~|value;
endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [MSB:0]     carry;     // carry[i] enters bit i
    logic [MSB:0]     less_vec;
    logic             set_lt;
    logic             ovf_raw;

    assign op       = alu_op_e'(op_sel);
    assign carry[0] = inv_b;
    assign less_vec = {{MSB{1'b0}}, set_lt};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == MSB) begin : g_top
            alu_msb_slice u_msb (
                .a_i      (a[i]),
                .b_i      (b[i]),
                .inv_a    (inv_a),
                .inv_b    (inv_b),
                .carry_in (carry[i]),
                .op       (op),
                .res      (result[i]),
                .prop     (prop[i]),
                .gen      (gen[i]),
                .ovf      (ovf_raw),
                .set_lt   (set_lt)
            );
        end else begin : g_low
            alu_slice u_slice (
                .a_i       (a[i]),
                .b_i       (b[i]),
                .inv_a     (inv_a),
                .inv_b     (inv_b),
                .carry_in  (carry[i]),
                .less_in   (less_vec[i]),
                .op        (op),
                .res       (result[i]),
                .carry_out (carry[i+1]),
                .prop      (prop[i]),
                .gen       (gen[i])
            );
        end
    end

    // Overflow only has meaning for the two arithmetic selections.
    assign overflow = ovf_raw & op_sel[1];

    alu_zero_flag #(.WIDTH(WIDTH)) u_zero (
        .value   (result),
        .is_zero (zero)
    );
endmodule

// File: rtl/alu_sliced_chk.sv
module alu_sliced_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             inv_a,
    input logic             inv_b,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow,
    input logic [WIDTH-1:0] prop,
    input logic [WIDTH-1:0] gen
);
    logic [WIDTH-1:0] a_m;
    logic [WIDTH-1:0] b_m;
    logic [WIDTH-1:0] add_ref;

    assign a_m     = inv_a ? ~a : a;
    assign b_m     = inv_b ? ~b : b;
    assign add_ref = a_m + b_m + {{(WIDTH-1){1'b0}}, inv_b};

    always_comb begin
        assert_and_R1: assert (op_sel != 2'b00 || result == (a_m & b_m));
        assert_or_R2: assert (op_sel != 2'b01 || result == (a_m | b_m));
        assert_add_sum_R3: assert (op_sel != 2'b10 || result == add_ref);
        assert_slt_upper_R5: assert (op_sel != 2'b11 || (result >> 1) == '0);
        assert_zero_R6: assert (zero == ($countones(result) == 0));
        assert_no_overflow_R8: assert (op_sel[1] || !overflow);
        assert_pg_R9: assert ((gen & ~prop) == '0 && prop == (a_m | b_m));
    end
endmodule

bind alu_sliced alu_sliced_chk #(.WIDTH(WIDTH)) u_chk (
    .a        (a),
    .b        (b),
    .inv_a    (inv_a),
    .inv_b    (inv_b),
    .op_sel   (op_sel),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .prop     (prop),
    .gen      (gen)
);

// File: tb/alu_sliced_tb.sv
module alu_sliced_tb;
    localparam int W4 = 4;
    localparam int W2 = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [W4-1:0] a4, b4, res4, p4, g4;
    logic [W2-1:0] res2, p2, g2;
    logic          inv_a, inv_b;
    logic [1:0]    op_sel;
    logic          z4, o4, z2, o2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    alu_sliced #(.WIDTH(W4)) u_dut (
        .a(a4), .b(b4), .inv_a(inv_a), .inv_b(inv_b), .op_sel(op_sel),
        .result(res4), .zero(z4), .overflow(o4), .prop(p4), .gen(g4)
    );

    alu_sliced #(.WIDTH(W2)) u_dut_w2 (
        .a(a4[W2-1:0]), .b(b4[W2-1:0]), .inv_a(inv_a), .inv_b(inv_b), .op_sel(op_sel),
        .result(res2), .zero(z2), .overflow(o2), .prop(p2), .gen(g2)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d ia=%0d ib=%0d op=%0d)",
                     tag, act, exp, a4, b4, inv_a, inv_b, op_sel);
        end
    endtask

    // Behavioural reference from the requirements, using signed integers.
    task automatic verify(input int w, input int ra, input int rb,
                          input int res, input int zf, input int of, input int p, input int g);
        int mask = (1 << w) - 1;
        int an = int'(inv_a);
        int bn = int'(inv_b);
        int op = int'(op_sel);
        int ap = an ? (~ra & mask) : (ra & mask);
        int bp = bn ? (~rb & mask) : (rb & mask);
        int sa = (ap >= (1 << (w-1))) ? ap - (1 << w) : ap;
        int sb = (bp >= (1 << (w-1))) ? bp - (1 << w) : bp;
        int ssum = sa + sb + bn;
        int ov_ar = (ssum > (1 << (w-1)) - 1 || ssum < -(1 << (w-1))) ? 1 : 0;
        int e_res;
        int e_ov;
        string tag;
        case (op)
            0: begin e_res = ap & bp; tag = "R1"; end
            1: begin e_res = ap | bp; tag = "R2"; end
            2: begin
                e_res = (ap + bp + bn) & mask;
                tag = (an == 0 && bn == 1) ? "R4" : "R3";
                if (an == 0 && bn == 1)
                    check(e_res == (((ra & mask) - (rb & mask)) & mask), "R4", e_res, ra - rb);
            end
            default: begin e_res = (ssum < 0) ? 1 : 0; tag = "R5"; end
        endcase
        e_ov = (op >= 2) ? ov_ar : 0;
        check(res == e_res, tag, res, e_res);
        check(zf == ((e_res == 0) ? 1 : 0), "R6", zf, (e_res == 0) ? 1 : 0);
        check(of == e_ov, (op >= 2) ? "R7" : "R8", of, e_ov);
        check(p == (ap | bp), "R9 prop", p, ap | bp);
        check(g == (ap & bp), "R9 gen", g, ap & bp);
    endtask

    initial begin
        a4 = '0; b4 = '0; inv_a = 1'b0; inv_b = 1'b0; op_sel = 2'b00;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Quiet state: all-zero inputs give a zero result and no overflow.
        check(res4 == 0 && z4 == 1'b1 && o4 == 1'b0, "R6 quiet", int'(res4), 0);
        // Width sweep covers R10 at two widths (4 and 2).
        for (int neg = 0; neg < 4; neg++) begin
            for (int op = 0; op < 4; op++) begin
                for (int ia = 0; ia < 16; ia++) begin
                    for (int ib = 0; ib < 16; ib++) begin
                        @(posedge clk);
                        #1;
                        inv_a  = neg[1];
                        inv_b  = neg[0];
                        op_sel = op[1:0];
                        a4     = ia[3:0];
                        b4     = ib[3:0];
                        @(negedge clk);
                        verify(W4, ia, ib, int'(res4), int'(z4), int'(o4), int'(p4), int'(g4));
                        verify(W2, ia, ib, int'(res2), int'(z2), int'(o2), int'(p2), int'(g2));
                    end
                end
            end
        end
        // Overflowing compare: -8 < 7 must still report true (R5).
        @(posedge clk);
        #1;
        inv_a = 1'b0; inv_b = 1'b1; op_sel = 2'b11; a4 = 4'b1000; b4 = 4'b0111;
        @(negedge clk);
        check(res4 == 4'd1 && o4 == 1'b1, "R5 overflowed compare", int'(res4), 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule